// File: doc/BRIEF.md
# DMA Channel Interrupt Coalescer

This block generates the interrupt for one channel of a descriptor-based DMA engine. The channel datapath sends a one-cycle pulse each time it retires a descriptor, and another one-cycle pulse when it hits an error. Interrupts are coalesced in two ways. A completion interrupt is raised once a programmed number of descriptors have retired. A delay interrupt is raised when some retired descriptors have not yet been reported and the channel has produced no new completion for a programmed number of timer ticks. Errors raise their own flag.

Software controls the block through two 32-bit registers on a single-cycle write / combinational read bus. The control register holds the run bit, a self-clearing channel reset, the three interrupt enables and the two thresholds. The status register holds the three sticky flags, which are cleared by writing ones, and the number of completions not yet reported. The delay timer advances once per prescaled tick. The prescaler divides the clock by `PRESCALE` and runs only while the channel is running.

Top module: `dma_irq_coalescer`

## Requirements
- R1: After hardware reset the control register reads 0xFE180000: delay limit 254 in bits 31:24, completion limit 24 in bits 23:16, and every other bit 0. The status register reads 0, and `irq`, `chan_run` and `chan_reset` are low.
- R2: Register select 0 is control and register select 1 is status. In control, bit 0 is run, bit 2 is reset in progress, bits 14:12 are the enables (error, delay, completion), bits 23:16 are the completion limit and bits 31:24 are the delay limit. In status, bits 14:12 are the flags in the same order and bits 23:16 are the count of unreported completions. A control write without bit 2 set stores all of these fields.
- R3: Each accepted completion pulse increments the unreported count. The pulse that brings the count up to the completion limit instead sets the completion flag and returns the count to 0. A limit of 0 behaves as a limit of 1.
- R4: While the unreported count is non-zero, the delay timer restarts on every completion and otherwise advances on each tick, with one tick every `PRESCALE` cycles of running. On the tick that reaches the delay limit (0 behaves as 1), it sets the delay flag and clears the unreported count.
- R5: An accepted error pulse sets the error flag (status bit 14).
- R6: Writing status clears each flag whose bit 14:12 is written as one. A flag being set in the same cycle as its clear stays set.
- R7: `irq` is high exactly when some flag is set together with its enable. Flags still latch while their enable is 0, and they drive `irq` as soon as the enable is written back to 1.
- R8: While run is 0, completion and error pulses are ignored. The count, the timer and the flags hold.
- R9: A control write with bit 2 set clears run, the flags, the count and the timer. Control bit 2 and `chan_reset` then read 1 for `RST_CYCLES` cycles and then return to 0. During that time, register writes and pulses are ignored.
- R10: A completion that arrives on the same cycle as a delay timeout takes priority. It is counted and restarts the timer, and no delay flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 control, 1 status |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the selected register |
| done_pulse | input | 1 | One pulse per retired descriptor |
| err_pulse | input | 1 | Channel error pulse |
| irq | output | 1 | Combined interrupt request |
| chan_run | output | 1 | Channel run enable to the datapath |
| chan_reset | output | 1 | Channel reset in progress |

## Verification
The bench builds the block with `PRESCALE` set to 2 and `RST_CYCLES` set to 4, keeping the default limits of 24 and 254. With these values, delay timeouts complete within a few cycles once small limits are written, and a whole reset window, including a write blocked inside it, fits in a short sequence. The short prescale period also makes a tick coincide with back-to-back completions, which exercises the rule that a completion outranks a timeout. A behavioural model, updated every cycle, follows the prescaler phase, so the exact cycle of every delay flag is compared.

// File: rtl/irq_coal_pkg.sv
package irq_coal_pkg;
    // Register field layout (software decodes these positions)
    localparam int FW       = 8;
    localparam int BIT_RUN  = 0;
    localparam int BIT_RST  = 2;
    localparam int FLG_LSB  = 12;
    localparam int NFLG     = 3;
    localparam int CNT_LSB  = 16;
    localparam int DLY_LSB  = 24;
    // Flag vector index: [0] completion, [1] delay, [2] error
    localparam int F_CMP    = 0;
    localparam int F_DLY    = 1;
    localparam int F_ERR    = 2;
    localparam logic ADDR_CTL = 1'b0;
    localparam logic ADDR_STS = 1'b1;
endpackage

// File: rtl/irq_coal_tick.sv
module irq_coal_tick #(
    parameter int PRESCALE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick
);
    generate
        if (PRESCALE <= 1) begin : g_direct
            logic sink_unused;
            assign sink_unused = clk ^ rst_n;
            assign tick = !hold;
        end else begin : g_div
            localparam int PW = $clog2(PRESCALE);
            localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
            typedef struct packed {
                logic [PW-1:0] cnt;
            } tick_st_t;
            tick_st_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                if (hold) begin
                    st_d.cnt = '0;
                end else if (st_q.cnt == LAST) begin
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign tick = !hold && (st_q.cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/irq_coal_count.sv
module irq_coal_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         enable,
    input  logic         done,
    input  logic         dly_hit,
    input  logic [W-1:0] limit,
    output logic         cmp_hit,
    output logic         pending,
    output logic [W-1:0] count
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;
    cnt_st_t st_d, st_q;

    logic [W:0] eff_lim;
    logic [W:0] nxt;

    always_comb begin
        eff_lim = (limit == '0) ? (W+1)'(1) : {1'b0, limit};
        nxt     = {1'b0, st_q.cnt} + 1'b1;
        cmp_hit = enable && done && (nxt >= eff_lim);
        st_d    = st_q;
        if (clear) begin
            st_d.cnt = '0;
        end else if (enable && done) begin
            st_d.cnt = cmp_hit ? '0 : nxt[W-1:0];
        end else if (dly_hit) begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.cnt;
    assign pending = (st_q.cnt != '0);
endmodule

// File: rtl/irq_coal_delay.sv
module irq_coal_delay #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         enable,
    input  logic         done,
    input  logic         tick,
    input  logic         pending,
    input  logic [W-1:0] limit,
    output logic         dly_hit
);
    typedef struct packed {
        logic [W-1:0] tmr;
    } dly_st_t;
    dly_st_t st_d, st_q;

    logic [W:0] eff_lim;
    logic [W:0] step;

    always_comb begin
        eff_lim = (limit == '0) ? (W+1)'(1) : {1'b0, limit};
        step    = {1'b0, st_q.tmr} + 1'b1;
        // a completion in the same cycle outranks the timeout
        dly_hit = enable && !done && pending && tick && (step >= eff_lim);
        st_d    = st_q;
        if (clear) begin
            st_d.tmr = '0;
        end else if (enable && done) begin
            st_d.tmr = '0;
        end else if (!pending) begin
            st_d.tmr = '0;
        end else if (enable && tick) begin
            st_d.tmr = dly_hit ? '0 : step[W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dma_irq_coalescer.sv
module dma_irq_coalescer
    import irq_coal_pkg::*;
#(
    parameter int PRESCALE   = 16,
    parameter int RST_CYCLES = 16,
    parameter int DEF_COUNT  = 24,
    parameter int DEF_DELAY  = 254
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        done_pulse,
    input  logic        err_pulse,
    output logic        irq,
    output logic        chan_run,
    output logic        chan_reset
);
    localparam int RW = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic            run;
        logic [NFLG-1:0] en;
        logic [FW-1:0]   cnt_thr;
        logic [FW-1:0]   dly_thr;
        logic [NFLG-1:0] flags;
        logic [RW-1:0]   rst_cnt;
    } ctl_st_t;

    localparam ctl_st_t RESET_ST = '{
        run:     1'b0,
        en:      '0,
        cnt_thr: FW'(DEF_COUNT),
        dly_thr: FW'(DEF_DELAY),
        flags:   '0,
        rst_cnt: '0
    };

    ctl_st_t st_d, st_q;

    logic          busy, active, wr_ctl, wr_sts, start_rst, clr;
    logic          tick, cmp_hit, dly_hit, pending;
    logic [FW-1:0] count;
    logic          wdata_unused;

    // plain views for the bound checker
    logic [NFLG-1:0] flag_vec, en_vec;
    logic [FW-1:0]   cnt_val;

    assign busy      = (st_q.rst_cnt != '0);
    assign active    = st_q.run && !busy;
    assign wr_ctl    = bus_wr && (bus_addr == ADDR_CTL) && !busy;
    assign wr_sts    = bus_wr && (bus_addr == ADDR_STS) && !busy;
    assign start_rst = wr_ctl && bus_wdata[BIT_RST];
    assign clr       = busy || start_rst;
    assign wdata_unused = ^bus_wdata;

    irq_coal_tick #(.PRESCALE(PRESCALE)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (!active),
        .tick  (tick)
    );

    irq_coal_count #(.W(FW)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clr),
        .enable  (active),
        .done    (done_pulse),
        .dly_hit (dly_hit),
        .limit   (st_q.cnt_thr),
        .cmp_hit (cmp_hit),
        .pending (pending),
        .count   (count)
    );

    irq_coal_delay #(.W(FW)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clr),
        .enable  (active),
        .done    (done_pulse),
        .tick    (tick),
        .pending (pending),
        .limit   (st_q.dly_thr),
        .dly_hit (dly_hit)
    );

    always_comb begin
        st_d = st_q;
        if (wr_ctl) begin
            st_d.en      = bus_wdata[FLG_LSB +: NFLG];
            st_d.cnt_thr = bus_wdata[CNT_LSB +: FW];
            st_d.dly_thr = bus_wdata[DLY_LSB +: FW];
            st_d.run     = bus_wdata[BIT_RUN] && !bus_wdata[BIT_RST];
        end
        if (wr_sts) begin
            st_d.flags = st_q.flags & ~bus_wdata[FLG_LSB +: NFLG];
        end
        // sets after clears: a new event survives a simultaneous clear
        if (active) begin
            if (cmp_hit)   st_d.flags[F_CMP] = 1'b1;
            if (dly_hit)   st_d.flags[F_DLY] = 1'b1;
            if (err_pulse) st_d.flags[F_ERR] = 1'b1;
        end
        if (busy) begin
            st_d.rst_cnt = st_q.rst_cnt - 1'b1;
            st_d.flags   = '0;
            st_d.run     = 1'b0;
        end
        if (start_rst) begin
            st_d.rst_cnt = RW'(RST_CYCLES);
            st_d.flags   = '0;
            st_d.run     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_CTL) begin
            bus_rdata[DLY_LSB +: FW]   = st_q.dly_thr;
            bus_rdata[CNT_LSB +: FW]   = st_q.cnt_thr;
            bus_rdata[FLG_LSB +: NFLG] = st_q.en;
            bus_rdata[BIT_RST]         = busy;
            bus_rdata[BIT_RUN]         = st_q.run;
        end else begin
            bus_rdata[CNT_LSB +: FW]   = count;
            bus_rdata[FLG_LSB +: NFLG] = st_q.flags;
        end
    end

    assign irq        = |(st_q.flags & st_q.en);
    assign chan_run   = st_q.run;
    assign chan_reset = busy;
    assign flag_vec   = st_q.flags;
    assign en_vec     = st_q.en;
    assign cnt_val    = count;
endmodule

// File: rtl/irq_coal_checker.sv
module irq_coal_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic        bus_addr,
    input logic [31:0] bus_wdata,
    input logic        done_pulse,
    input logic        err_pulse,
    input logic        irq,
    input logic        chan_run,
    input logic        chan_reset,
    input logic [2:0]  flags,
    input logic [2:0]  en,
    input logic [7:0]  count
);
    AST_CMP_FROM_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> $past(done_pulse)); // R3

    AST_DLY_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[1]) |-> (count == 8'd0)); // R4

    AST_ERR_FROM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[2]) |-> $past(err_pulse)); // R5

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (en == 3'b000) |-> !irq); // R7

    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_run && !chan_reset && !(bus_wr && !bus_addr && bus_wdata[2]))
        |=> $stable(count)); // R8

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        chan_reset |-> (flags == 3'b000 && !chan_run && count == 8'd0)); // R9
endmodule

bind dma_irq_coalescer irq_coal_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .done_pulse (done_pulse),
    .err_pulse  (err_pulse),
    .irq        (irq),
    .chan_run   (chan_run),
    .chan_reset (chan_reset),
    .flags      (flag_vec),
    .en         (en_vec),
    .count      (cnt_val)
);

// File: tb/sim_dma_irq_coalescer.sv
`timescale 1ns/1ps
module sim_dma_irq_coalescer;
    localparam int P  = 2;
    localparam int RC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        done_pulse = 1'b0;
    logic        err_pulse = 1'b0;
    logic        irq, chan_run, chan_reset;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dma_irq_coalescer #(.PRESCALE(P), .RST_CYCLES(RC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_pulse(done_pulse),
        .err_pulse(err_pulse), .irq(irq), .chan_run(chan_run), .chan_reset(chan_reset)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_run = 0, m_en = 0, m_cthr = 24, m_dthr = 254, m_flags = 0;
    int m_cnt = 0, m_tmr = 0, m_pc = 0, m_rst = 0;

    task automatic mreset();
        m_run = 0; m_en = 0; m_cthr = 24; m_dthr = 254; m_flags = 0;
        m_cnt = 0; m_tmr = 0; m_pc = 0; m_rst = 0;
    endtask

    task automatic mstep();
        bit busy, act, tick, cmp, dly, wc, ws, st;
        int lc, ld, ncnt, ntmr, nf, npc;
        busy = (m_rst > 0);
        act  = (m_run != 0) && !busy;
        tick = act && (m_pc == P - 1);
        lc   = (m_cthr == 0) ? 1 : m_cthr;
        ld   = (m_dthr == 0) ? 1 : m_dthr;
        ncnt = m_cnt; ntmr = m_tmr; nf = m_flags; cmp = 0; dly = 0;
        wc = bus_wr && (bus_addr == 1'b0) && !busy;
        ws = bus_wr && (bus_addr == 1'b1) && !busy;
        st = wc && bus_wdata[2];
        if (act && done_pulse) begin
            if (m_cnt + 1 >= lc) begin cmp = 1; ncnt = 0; end
            else ncnt = m_cnt + 1;
            ntmr = 0;
        end else if (m_cnt == 0) begin
            ntmr = 0;
        end else if (tick) begin
            if (m_tmr + 1 >= ld) begin dly = 1; ncnt = 0; ntmr = 0; end
            else ntmr = m_tmr + 1;
        end
        npc = !act ? 0 : ((m_pc == P - 1) ? 0 : m_pc + 1);
        if (ws) nf = nf & ~int'(bus_wdata[14:12]);
        if (act) begin
            if (cmp) nf = nf | 1;
            if (dly) nf = nf | 2;
            if (err_pulse) nf = nf | 4;
        end
        if (wc) begin
            m_dthr = int'(bus_wdata[31:24]);
            m_cthr = int'(bus_wdata[23:16]);
            m_en   = int'(bus_wdata[14:12]);
            m_run  = (bus_wdata[0] && !bus_wdata[2]) ? 1 : 0;
        end
        if (busy) begin m_rst = m_rst - 1; nf = 0; m_run = 0; ncnt = 0; ntmr = 0; end
        if (st)   begin m_rst = RC; nf = 0; m_run = 0; ncnt = 0; ntmr = 0; end
        m_cnt = ncnt; m_tmr = ntmr; m_flags = nf; m_pc = npc;
    endtask

    function automatic logic [31:0] m_rdata(input logic a);
        if (a == 1'b0)
            return (32'(m_dthr) << 24) | (32'(m_cthr) << 16) | (32'(m_en) << 12)
                 | ((m_rst > 0) ? 32'h4 : 32'h0) | 32'(m_run);
        return (32'(m_cnt) << 16) | (32'(m_flags) << 12);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) mreset();
        else mstep();
        #1;
        if (rst_n) begin
            check("R2 model rdata", bus_rdata, m_rdata(bus_addr));
            check("R7 model irq", 32'(irq), ((m_flags & m_en) != 0) ? 32'd1 : 32'd0);
            check("R9 model chan_run", 32'(chan_run), 32'(m_run));
            check("R9 model chan_reset", 32'(chan_reset), (m_rst > 0) ? 32'd1 : 32'd0);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_chk(input logic a, input logic [31:0] exp, input string tag);
        @(negedge clk); bus_addr = a; #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic pulse_done(input int n);
        @(negedge clk); done_pulse = 1'b1;
        repeat (n) @(negedge clk);
        done_pulse = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk(1'b0, 32'hFE180000, "R1 control after reset");
        rd_chk(1'b1, 32'h00000000, "R1 status after reset");
        check("R1 irq after reset", 32'(irq), 32'd0);
        // R2 control layout
        wr(1'b0, 32'h03037001);
        rd_chk(1'b0, 32'h03037001, "R2 control readback");
        // R3 completion coalescing
        pulse_done(2);
        rd_chk(1'b1, 32'h00020000, "R2 pending count field");
        pulse_done(1);
        rd_chk(1'b1, 32'h00001000, "R3 completion flag at limit");
        check("R3 irq on completion", 32'(irq), 32'd1);
        // R6 write-one-to-clear
        wr(1'b1, 32'h00001000);
        rd_chk(1'b1, 32'h00000000, "R6 flag cleared");
        check("R6 irq dropped", 32'(irq), 32'd0);
        // R4 delay timeout
        pulse_done(1);
        @(negedge clk);
        rd_chk(1'b1, 32'h00010000, "R4 no timeout yet");
        repeat (10) @(negedge clk);
        rd_chk(1'b1, 32'h00002000, "R4 delay flag and count cleared");
        // R7 masking
        wr(1'b1, 32'h00007000);
        wr(1'b0, 32'h03030001);
        pulse_done(3);
        rd_chk(1'b1, 32'h00001000, "R7 flag latches while masked");
        check("R7 irq masked", 32'(irq), 32'd0);
        wr(1'b0, 32'h03031001);
        check("R7 irq after unmask", 32'(irq), 32'd1);
        // R5 error
        wr(1'b1, 32'h00007000);
        @(negedge clk); err_pulse = 1'b1;
        @(negedge clk); err_pulse = 1'b0;
        rd_chk(1'b1, 32'h00004000, "R5 error flag");
        // R6 set beats clear
        @(negedge clk); bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = 32'h00004000; err_pulse = 1'b1;
        @(negedge clk); bus_wr = 1'b0; bus_wdata = '0; err_pulse = 1'b0;
        rd_chk(1'b1, 32'h00004000, "R6 simultaneous set wins");
        // R8 stopped channel ignores pulses
        wr(1'b1, 32'h00007000);
        wr(1'b0, 32'h03031000);
        pulse_done(3);
        @(negedge clk); err_pulse = 1'b1;
        @(negedge clk); err_pulse = 1'b0;
        rd_chk(1'b1, 32'h00000000, "R8 pulses ignored when stopped");
        check("R8 run low", 32'(chan_run), 32'd0);
        // R3 zero limit acts as one
        wr(1'b0, 32'h03001001);
        pulse_done(1);
        rd_chk(1'b1, 32'h00001000, "R3 zero limit");
        // R9 soft reset
        wr(1'b1, 32'h00007000);
        wr(1'b0, 32'h03051001);
        pulse_done(1);
        wr(1'b0, 32'h03051005);
        check("R9 reset output high", 32'(chan_reset), 32'd1);
        check("R9 run cleared", 32'(chan_run), 32'd0);
        rd_chk(1'b0, 32'h03051004, "R9 reset bit reads busy");
        wr(1'b0, 32'h0A0A1001);
        repeat (3) @(negedge clk);
        rd_chk(1'b0, 32'h03051000, "R9 reset done, blocked write ignored");
        rd_chk(1'b1, 32'h00000000, "R9 count cleared");
        // R10 completion outranks timeout
        wr(1'b0, 32'h01051001);
        @(negedge clk); done_pulse = 1'b1; bus_addr = 1'b1;
        repeat (4) @(negedge clk);
        #1 check("R10 stream keeps counting", bus_rdata, 32'h00040000);
        done_pulse = 1'b0;
        repeat (4) @(negedge clk);
        rd_chk(1'b1, 32'h00002000, "R4 timeout after stream");
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule